// File: doc/BRIEF.md
# Clock Output Select and Enable Controller

This block sits between a small configuration register bank and the output stage of a system clock generator. It works out which CPU/PCI frequency pair the synthesiser should produce. The choice comes either from a board-level speed pin or from a 3-bit code held in a control register. The block also decodes the operating mode, which is one of normal, test, spread-spectrum or high-impedance. The frequency synthesisers are outside the block, so their clocks arrive here as plain inputs.

Each clock output passes through its own glitch-free gate. A cleared enable bit stops that output and holds it low. The gate resamples its enable on the falling edge of its own source clock, so a clock pulse is never cut short. While the block is in reset it samples a strap pin. The strap decides whether the auxiliary USB-side output runs at the 48 MHz input rate or at half that rate. The high-impedance mode withdraws the drive of every pin, whatever the individual enable bits say.

Registers are written through a simple strobe port. `wr_idx` selects the target:
- 0 selects the control byte.
- 1 selects the PCI enable byte.
- 2 selects the miscellaneous enable byte.
- 3 selects nothing.

Top module: `clk_out_ctrl`

## Requirements
- R1: After reset the block is in the following state:
  - The control byte is 0, so the speed pin selects the frequency and the mode is normal.
  - Every enable bit is 1, so all twelve `run_o` bits are 1.
  - All twelve `out_drive_o` bits are 1.
- R2: When control bit 3 is 0, `freq_code_o` follows `hw_fast`. The code is 3'b111 (CPU 100.00 MHz, PCI 33.33 MHz) when the pin is high and 3'b011 (66.60/33.30 MHz) when it is low.
- R3: When control bit 3 is 1, `freq_code_o` equals control bits 6:4. `cpu_freq_o` and `pci_freq_o` report the pair in units of 10 kHz:

  | Code | CPU | PCI |
  |------|-----|-----|
  | 0 | 6850 | 3425 |
  | 1 | 7500 | 3750 |
  | 2 | 8330 | 4160 |
  | 3 | 6660 | 3330 |
  | 4 | 10300 | 3430 |
  | 5 | 11200 | 3730 |
  | 6 | 13330 | 4443 |
  | 7 | 10000 | 3333 |

- R4: Control bits 1:0 select the mode: 00 is normal with no flag set, 01 raises `test_mode_o`, 10 raises `spread_en_o` and 11 raises `tristate_o`. At most one of these flags is high at a time.
- R5: While the mode is 11, every `out_drive_o` bit is 0 and `run_o` is unaffected. In any other mode every `out_drive_o` bit is 1.
- R6: The `run_o` bits are laid out as follows:
  - [1:0] are the CPU outputs, taken from miscellaneous byte bits 1:0.
  - [7:2] are PCI outputs 0 to 5, taken from PCI byte bits 5:0.
  - [8] is the free-running PCI output, taken from PCI byte bit 6.
  - [9] is the IOAPIC output, taken from miscellaneous bit 2.
  - [11] is the auxiliary output, taken from miscellaneous bit 5.
- R7: `run_o[10]` (the REF output) is 1 only when both miscellaneous bits 3 and 4 are 1.
- R8: An output whose `run_o` bit is 0 stays low. An output whose bit is 1 toggles at its source rate. Enables take effect on a falling edge of the output's own source clock.
- R9: The `ref_strap` level seen during reset picks the auxiliary rate: 1 gives half the 48 MHz input and 0 gives the full 48 MHz input. Changes on the pin after reset have no effect.
- R10: Control bits 7 and 2 have no effect on any output. A write with `wr_idx` = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register select: 0 control, 1 PCI enables, 2 misc enables, 3 none |
| wr_data | input | 8 | Write data |
| hw_fast | input | 1 | Hardware speed pin: 1 = 100 MHz, 0 = 66.6 MHz |
| ref_strap | input | 1 | Strap level, sampled during reset |
| cpu_pll_clk | input | 1 | CPU synthesiser clock |
| pci_pll_clk | input | 1 | PCI synthesiser clock |
| ref_osc_clk | input | 1 | Crystal reference clock |
| usb_pll_clk | input | 1 | 48 MHz synthesiser clock |
| freq_code_o | output | 3 | Effective frequency code |
| cpu_freq_o | output | 16 | CPU frequency in 10 kHz units |
| pci_freq_o | output | 16 | PCI frequency in 10 kHz units |
| test_mode_o | output | 1 | Test mode active |
| spread_en_o | output | 1 | Spread-spectrum modulation enable |
| tristate_o | output | 1 | High-impedance mode active |
| run_o | output | 12 | Per-output run request |
| out_drive_o | output | 12 | Per-output pin drive enable |
| cpu_clk_o | output | 2 | Gated CPU clocks |
| pci_clk_o | output | 6 | Gated PCI clocks |
| pci_free_o | output | 1 | Gated free-running PCI clock |
| apic_clk_o | output | 1 | Gated IOAPIC clock |
| ref_clk_o | output | 1 | Gated reference clock |
| aux_clk_o | output | 1 | Gated 24/48 MHz clock |

## Verification
The strap choice is the hardest effect to reach from the ports. It can only be changed by a fresh reset, and its only visible result is the rate of one gated clock. The bench therefore runs two reset sequences with opposite strap levels and counts rising edges of the auxiliary output over a fixed window. In the second sequence it also flips the pin after reset to show the rate holds. Gate behaviour is observed in the same way, by sampling every output once per nanosecond over a window after an enable pattern has settled. A disabled output must show no high sample, and an enabled one must show repeated rising edges.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int CPU_N   = 2;
  localparam int PCI_N   = 6;
  localparam int FREQ_W  = 16;
  localparam int NUM_OUT = CPU_N + PCI_N + 4;
  localparam int PCIB_W  = PCI_N + 1;
  localparam int MISC_W  = CPU_N + 4;

  // run vector positions
  localparam int IDX_PCI0 = CPU_N;
  localparam int IDX_PCIF = CPU_N + PCI_N;
  localparam int IDX_APIC = IDX_PCIF + 1;
  localparam int IDX_REF  = IDX_PCIF + 2;
  localparam int IDX_AUX  = IDX_PCIF + 3;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_HIZ    = 2'b11
  } mode_e;

  // stored control fields (reserved bits are not kept)
  typedef struct packed {
    logic [2:0] code;
    logic       use_reg;
    logic [1:0] mode;
  } ctrl_t;

  localparam logic [2:0] CODE_HW_FAST = 3'b111;
  localparam logic [2:0] CODE_HW_SLOW = 3'b011;

  function automatic logic [2:0] pick_code(input logic use_reg, input logic [2:0] code,
                                           input logic hw_fast);
    if (use_reg) return code;
    return hw_fast ? CODE_HW_FAST : CODE_HW_SLOW;
  endfunction

  function automatic logic [FREQ_W-1:0] cpu_freq_10k(input logic [2:0] code);
    case (code)
      3'd0:    return FREQ_W'(6850);
      3'd1:    return FREQ_W'(7500);
      3'd2:    return FREQ_W'(8330);
      3'd3:    return FREQ_W'(6660);
      3'd4:    return FREQ_W'(10300);
      3'd5:    return FREQ_W'(11200);
      3'd6:    return FREQ_W'(13330);
      default: return FREQ_W'(10000);
    endcase
  endfunction

  function automatic logic [FREQ_W-1:0] pci_freq_10k(input logic [2:0] code);
    case (code)
      3'd0:    return FREQ_W'(3425);
      3'd1:    return FREQ_W'(3750);
      3'd2:    return FREQ_W'(4160);
      3'd3:    return FREQ_W'(3330);
      3'd4:    return FREQ_W'(3430);
      3'd5:    return FREQ_W'(3730);
      3'd6:    return FREQ_W'(4443);
      default: return FREQ_W'(3333);
    endcase
  endfunction

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              strap_in,
  output ctrl_t             ctrl_q,
  output logic [PCIB_W-1:0] pci_q,
  output logic [MISC_W-1:0] misc_q,
  output logic              strap_q
);

  logic unused_wr_bit;
  assign unused_wr_bit = wr_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pci_q  <= '1;
      misc_q <= '1;
    end else if (wr_en) begin
      case (wr_idx)
        2'd0: ctrl_q <= '{code: wr_data[6:4], use_reg: wr_data[3], mode: wr_data[1:0]};
        2'd1: pci_q  <= wr_data[PCIB_W-1:0];
        2'd2: misc_q <= wr_data[MISC_W-1:0];
        default: ;
      endcase
    end
  end

  // strap follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

endmodule

// File: rtl/clkctl_decode.sv
module clkctl_decode
  import clkctl_pkg::*;
(
  input  ctrl_t             ctrl,
  input  logic              hw_fast,
  output logic [2:0]        code_o,
  output logic [FREQ_W-1:0] cpu_f_o,
  output logic [FREQ_W-1:0] pci_f_o,
  output logic              test_o,
  output logic              spread_o,
  output logic              hiz_o
);

  mode_e mode;

  always_comb begin
    mode     = mode_e'(ctrl.mode);
    code_o   = pick_code(ctrl.use_reg, ctrl.code, hw_fast);
    cpu_f_o  = cpu_freq_10k(code_o);
    pci_f_o  = pci_freq_10k(code_o);
    test_o   = (mode == MODE_TEST);
    spread_o = (mode == MODE_SPREAD);
    hiz_o    = (mode == MODE_HIZ);
  end

endmodule

// File: rtl/clkctl_gate.sv
module clkctl_gate (
  input  logic src_clk,
  input  logic rst_n,
  input  logic run,
  output logic gated
);

  logic en_q;

  // enable moves only while the source is low, so no pulse is shortened
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= run;
  end

  assign gated = src_clk & en_q;

endmodule

// File: rtl/clk_out_ctrl.sv
module clk_out_ctrl
  import clkctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_idx,
  input  logic [7:0]         wr_data,
  input  logic               hw_fast,
  input  logic               ref_strap,
  input  logic               cpu_pll_clk,
  input  logic               pci_pll_clk,
  input  logic               ref_osc_clk,
  input  logic               usb_pll_clk,
  output logic [2:0]         freq_code_o,
  output logic [FREQ_W-1:0]  cpu_freq_o,
  output logic [FREQ_W-1:0]  pci_freq_o,
  output logic               test_mode_o,
  output logic               spread_en_o,
  output logic               tristate_o,
  output logic [NUM_OUT-1:0] run_o,
  output logic [NUM_OUT-1:0] out_drive_o,
  output logic [CPU_N-1:0]   cpu_clk_o,
  output logic [PCI_N-1:0]   pci_clk_o,
  output logic               pci_free_o,
  output logic               apic_clk_o,
  output logic               ref_clk_o,
  output logic               aux_clk_o
);

  ctrl_t              ctrl_q;
  logic [PCIB_W-1:0]  pci_q;
  logic [MISC_W-1:0]  misc_q;
  logic               strap_q;
  logic               ref_pair_ok;
  logic               half48_q;
  logic               aux_src;
  logic [NUM_OUT-1:0] src_clk;
  logic [NUM_OUT-1:0] gated;

  clkctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .strap_in (ref_strap),
    .ctrl_q   (ctrl_q),
    .pci_q    (pci_q),
    .misc_q   (misc_q),
    .strap_q  (strap_q)
  );

  clkctl_decode u_dec (
    .ctrl     (ctrl_q),
    .hw_fast  (hw_fast),
    .code_o   (freq_code_o),
    .cpu_f_o  (cpu_freq_o),
    .pci_f_o  (pci_freq_o),
    .test_o   (test_mode_o),
    .spread_o (spread_en_o),
    .hiz_o    (tristate_o)
  );

  // both REF drivers must agree before the pin runs
  assign ref_pair_ok = misc_q[CPU_N+1] & misc_q[CPU_N+2];

  assign run_o = {misc_q[CPU_N+3], ref_pair_ok, misc_q[CPU_N], pci_q[PCI_N],
                  pci_q[PCI_N-1:0], misc_q[CPU_N-1:0]};

  assign out_drive_o = {NUM_OUT{~tristate_o}};

  // half-rate auxiliary clock from the 48 MHz input
  always_ff @(posedge usb_pll_clk or negedge rst_n) begin
    if (!rst_n) half48_q <= 1'b0;
    else        half48_q <= ~half48_q;
  end

  assign aux_src = strap_q ? half48_q : usb_pll_clk;

  assign src_clk = {aux_src, ref_osc_clk, ref_osc_clk, {(PCI_N+1){pci_pll_clk}},
                    {CPU_N{cpu_pll_clk}}};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
    clkctl_gate u_gate (
      .src_clk (src_clk[g]),
      .rst_n   (rst_n),
      .run     (run_o[g]),
      .gated   (gated[g])
    );
  end

  assign cpu_clk_o  = gated[CPU_N-1:0];
  assign pci_clk_o  = gated[IDX_PCI0 +: PCI_N];
  assign pci_free_o = gated[IDX_PCIF];
  assign apic_clk_o = gated[IDX_APIC];
  assign ref_clk_o  = gated[IDX_REF];
  assign aux_clk_o  = gated[IDX_AUX];

endmodule

// File: rtl/clk_out_ctrl_chk.sv
module clk_out_ctrl_chk
  import clkctl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         wr_idx,
  input logic               hw_fast,
  input logic [5:0]         ctrl_q,
  input logic [PCIB_W-1:0]  pci_q,
  input logic [MISC_W-1:0]  misc_q,
  input logic               strap_q,
  input logic [2:0]         freq_code_o,
  input logic               test_mode_o,
  input logic               spread_en_o,
  input logic               tristate_o,
  input logic [NUM_OUT-1:0] run_o,
  input logic [NUM_OUT-1:0] out_drive_o
);

  p_hw_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[2] |-> (freq_code_o == (hw_fast ? 3'b111 : 3'b011)));

  p_reg_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[2] |-> (freq_code_o == ctrl_q[5:3]));

  p_mode_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({test_mode_o, spread_en_o, tristate_o}));

  p_hiz_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tristate_o |-> (out_drive_o == '0));

  p_drive_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tristate_o |-> (&out_drive_o));

  p_ref_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_o[IDX_REF] |-> (misc_q[CPU_N+1] && misc_q[CPU_N+2]));

  p_strap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap_q));

  p_idx3_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 2'd3) |=> ($stable(ctrl_q) && $stable(pci_q) && $stable(misc_q)));

endmodule

bind clk_out_ctrl clk_out_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .hw_fast     (hw_fast),
  .ctrl_q      (ctrl_q),
  .pci_q       (pci_q),
  .misc_q      (misc_q),
  .strap_q     (strap_q),
  .freq_code_o (freq_code_o),
  .test_mode_o (test_mode_o),
  .spread_en_o (spread_en_o),
  .tristate_o  (tristate_o),
  .run_o       (run_o),
  .out_drive_o (out_drive_o)
);

// File: tb/tb_clk_out_ctrl.sv
`timescale 1ns/1ps
module tb_clk_out_ctrl;

  logic clk = 1'b0, cpu_c = 1'b0, pci_c = 1'b0, ref_c = 1'b0, usb_c = 1'b0;
  logic rst_n = 1'b0, wr_en = 1'b0, hw_fast = 1'b1, ref_strap = 1'b0;
  logic [1:0] wr_idx = 2'd0;
  logic [7:0] wr_data = 8'd0;

  logic [2:0]  freq_code_o;
  logic [15:0] cpu_freq_o, pci_freq_o;
  logic test_mode_o, spread_en_o, tristate_o;
  logic [11:0] run_o, out_drive_o;
  logic [1:0] cpu_clk_o;
  logic [5:0] pci_clk_o;
  logic pci_free_o, apic_clk_o, ref_clk_o, aux_clk_o;

  always #5  clk   = ~clk;
  always #3  cpu_c = ~cpu_c;
  always #7  pci_c = ~pci_c;
  always #17 ref_c = ~ref_c;
  always #5  usb_c = ~usb_c;

  clk_out_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .hw_fast(hw_fast), .ref_strap(ref_strap), .cpu_pll_clk(cpu_c), .pci_pll_clk(pci_c),
    .ref_osc_clk(ref_c), .usb_pll_clk(usb_c), .freq_code_o(freq_code_o),
    .cpu_freq_o(cpu_freq_o), .pci_freq_o(pci_freq_o), .test_mode_o(test_mode_o),
    .spread_en_o(spread_en_o), .tristate_o(tristate_o), .run_o(run_o),
    .out_drive_o(out_drive_o), .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o),
    .pci_free_o(pci_free_o), .apic_clk_o(apic_clk_o), .ref_clk_o(ref_clk_o),
    .aux_clk_o(aux_clk_o)
  );

  wire [11:0] outs = {aux_clk_o, ref_clk_o, apic_clk_o, pci_free_o, pci_clk_o, cpu_clk_o};

  int n_chk = 0, n_fail = 0;
  int rises[12];
  int highs[12];
  bit done = 1'b0;

  int cpu_tab[8] = '{6850, 7500, 8330, 6660, 10300, 11200, 13330, 10000};
  int pci_tab[8] = '{3425, 3750, 4160, 3330, 3430, 3730, 4443, 3333};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input logic [7:0] c, input logic hw);
    if (c[3]) return c[6:4];
    return hw ? 3'd7 : 3'd3;
  endfunction

  function automatic logic [11:0] exp_run(input logic [7:0] p, input logic [7:0] m);
    return {m[5], m[3] & m[4], m[2], p[6], p[5:0], m[1:0]};
  endfunction

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk); rst_n = 1'b0; ref_strap = strap;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic observe(input int ns);
    logic [11:0] prev = outs;
    for (int i = 0; i < 12; i++) begin rises[i] = 0; highs[i] = 0; end
    for (int t = 0; t < ns; t++) begin
      #1;
      for (int i = 0; i < 12; i++) begin
        if (outs[i]) highs[i]++;
        if (outs[i] && !prev[i]) rises[i]++;
      end
      prev = outs;
    end
  endtask

  task automatic check_ctrl(input logic [7:0] c, input string req);
    logic [2:0] ec = exp_code(c, hw_fast);
    chk(freq_code_o == ec, req, freq_code_o, ec);
    chk(cpu_freq_o == 16'(cpu_tab[ec]), "R3 cpu freq", cpu_freq_o, cpu_tab[ec]);
    chk(pci_freq_o == 16'(pci_tab[ec]), "R3 pci freq", pci_freq_o, pci_tab[ec]);
    chk({test_mode_o, spread_en_o, tristate_o} ==
        {c[1:0] == 2'b01, c[1:0] == 2'b10, c[1:0] == 2'b11}, "R4 mode flags",
        {test_mode_o, spread_en_o, tristate_o}, c[1:0]);
    chk(out_drive_o == ((c[1:0] == 2'b11) ? 12'h000 : 12'hFFF), "R5 drive",
        out_drive_o, c[1:0]);
  endtask

  task automatic check_gates(input logic [11:0] er, input string req);
    for (int i = 0; i < 12; i++) begin
      if (er[i]) chk(rises[i] >= 2, req, rises[i], 2);
      else       chk(highs[i] == 0, req, highs[i], 0);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset(1'b0);

    // R1 defaults
    chk(run_o == 12'hFFF, "R1 run defaults", run_o, 12'hFFF);
    chk(out_drive_o == 12'hFFF, "R1 drive defaults", out_drive_o, 12'hFFF);
    check_ctrl(8'h00, "R1 R2 default code");

    // R8/R9: everything runs, aux at full 48 rate with strap 0
    observe(400);
    check_gates(12'hFFF, "R8 all running");
    chk(rises[11] >= 36 && rises[11] <= 44, "R9 aux 48", rises[11], 40);

    // R2 pin low
    @(negedge clk); hw_fast = 1'b0;
    @(negedge clk);
    check_ctrl(8'h00, "R2 pin low");

    // R4 directed modes, R10 reserved bits set
    wr(2'd0, 8'h01); check_ctrl(8'h01, "R4 test");
    wr(2'd0, 8'h02); check_ctrl(8'h02, "R4 spread");
    wr(2'd0, 8'h03); check_ctrl(8'h03, "R5 hiz");
    chk(run_o == 12'hFFF, "R5 run kept in hiz", run_o, 12'hFFF);
    wr(2'd0, 8'h84); check_ctrl(8'h84, "R10 reserved bits");

    // R3 every code directly
    for (int k = 0; k < 8; k++) begin
      wr(2'd0, {1'b0, 3'(k), 1'b1, 3'b000});
      check_ctrl({1'b0, 3'(k), 1'b1, 3'b000}, "R3 code");
    end

    // random control writes
    for (int n = 0; n < 40; n++) begin
      logic [7:0] c = 8'($urandom);
      @(negedge clk); hw_fast = 1'($urandom);
      wr(2'd0, c);
      check_ctrl(c, "R2 R3 random");
    end

    // R6/R7 random enables
    for (int n = 0; n < 24; n++) begin
      logic [7:0] p = 8'($urandom);
      logic [7:0] m = 8'($urandom);
      wr(2'd1, p); wr(2'd2, m);
      chk(run_o == exp_run(p, m), "R6 R7 run map", run_o, exp_run(p, m));
    end

    // R7 directed pair
    wr(2'd1, 8'h7F);
    wr(2'd2, 8'h37); chk(run_o[10] == 1'b0, "R7 one bit low", run_o[10], 0);
    wr(2'd2, 8'h2F); chk(run_o[10] == 1'b0, "R7 other bit low", run_o[10], 0);
    wr(2'd2, 8'h3F); chk(run_o[10] == 1'b1, "R7 both high", run_o[10], 1);

    // R8 gating pattern
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h25);
    #100;
    observe(200);
    check_gates(exp_run(8'h55, 8'h25), "R8 pattern");

    // R5 hiz leaves clocks and run alone
    wr(2'd0, 8'h03);
    chk(out_drive_o == 12'h000, "R5 hiz drive", out_drive_o, 0);
    chk(run_o == exp_run(8'h55, 8'h25), "R5 run kept", run_o, exp_run(8'h55, 8'h25));

    // R10 index 3 ignored
    wr(2'd3, 8'h00);
    chk(run_o == exp_run(8'h55, 8'h25), "R10 idx3 run", run_o, exp_run(8'h55, 8'h25));
    chk(tristate_o == 1'b1, "R10 idx3 ctrl", tristate_o, 1);

    // R9 strap high, then pin moves after reset
    do_reset(1'b1);
    chk(run_o == 12'hFFF, "R1 run after second reset", run_o, 12'hFFF);
    ref_strap = 1'b0;
    #100;
    observe(400);
    chk(rises[11] >= 18 && rises[11] <= 22, "R9 aux 24", rises[11], 20);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule